// File: doc/BRIEF.md
# Spread Spectrum Mode Selector

This block chooses how much down-spread a clock synthesizer applies and produces the modulation code that drives its fractional feedback divider. At the first rising edge of the power-good input it captures a three-level configuration strap (already decoded to low, mid or high). That captured value sets the default spread depth. It is also reported on a read-only readback field, which does not change again until reset.

Software can override the strap. It sets an override enable and writes a two-bit mode field. The mode field has no effect while the enable is clear.

The modulation output is a signed divider offset. It moves in a symmetric triangle between zero and the negative full depth of the active mode, so the synthesized frequency never rises above nominal. An up/down step counter advances the offset once every `TICK_DIV` clock cycles. The step size is fixed per mode, so every half period ends exactly on the depth limit. A new mode is taken up only when the offset passes through zero, which keeps the divider code free of jumps.

Top module: `ssc_mode_sel`

## Requirements
- R1: On the first rising edge of `pwr_good` after reset, the strap level (`strap_lvl` encoding 00 = low, 01 = mid, 10 = high) is captured. From the next clock edge, `strap_rb` reads 00 for low, 01 for mid and 11 for high. After reset and before that edge, `strap_rb` reads 00.
- R2: Later rising edges of `pwr_good` do not capture the strap again. `strap_rb` keeps its first value even if `strap_lvl` changes.
- R3: Until the strap has been captured, `div_ofs` is 0 and `mode_act` is 00, whatever the override inputs are.
- R4: While `sw_ovr_en` is 0, the captured strap selects the mode and `sw_mode` has no effect. The strap mapping is: low = off, mid = quarter depth, high = full depth.
- R5: While `sw_ovr_en` is 1, `sw_mode` selects the mode: 00 = off, 01 = quarter depth, 11 = full depth. The reserved code 10 acts as off.
- R6: The offset is never positive. Its most negative value is -(HALF_STEPS*STEP_QTR) in quarter mode and -(HALF_STEPS*2*STEP_QTR) in full mode. With the defaults these are -64 and -128. In off mode the offset stays at 0.
- R7: Each change of `div_ofs` has a magnitude of exactly the active step: STEP_QTR (4) in quarter mode, 2*STEP_QTR (8) in full mode. The triangle repeats every 2*HALF_STEPS*TICK_DIV clock cycles, which is 128 with the defaults.
- R8: `mode_act` (00 off, 01 quarter, 11 full) changes only at a step taken from an offset of 0. A mode request made mid-ramp waits for the ramp to return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Power-good; its first rising edge captures the strap |
| strap_lvl | input | 2 | Decoded strap level: 00 low, 01 mid, 10 high |
| sw_ovr_en | input | 1 | Software override enable |
| sw_mode | input | 2 | Software spread mode request |
| strap_rb | output | 2 | Readback of the captured strap |
| mode_act | output | 2 | Mode currently applied to the modulator |
| div_ofs | output | OFS_W | Signed divider offset (0 down to minus depth) |

## Verification
The bench moves the strap after the first power-good edge and pulses power-good again. A design that re-latches would show a changed readback. It sets a full-depth code in the mode field while the override is clear; a design that leaks the field would double the depth. It drives the reserved mode code, which a naive decoder would read as some nonzero spread. It requests a mode change in the middle of a ramp. A design that switches at once would show a mode change away from zero, or an offset step that is neither 4 nor 8. Every window also checks the most negative offset and the cycle distance between successive troughs. This catches step sizes that overshoot the depth or counters that miss the turn.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        STRAP_LO  = 2'b00,
        STRAP_MID = 2'b01,
        STRAP_HI  = 2'b10
    } strap_e;

    typedef enum logic [1:0] {
        SS_OFF  = 2'b00,
        SS_QTR  = 2'b01,
        SS_RSV  = 2'b10,
        SS_FULL = 2'b11
    } ss_mode_e;

    // Readback code of a captured strap level
    function automatic logic [1:0] strap_code(input logic [1:0] lvl);
        case (lvl)
            STRAP_MID: return 2'b01;
            STRAP_LO:  return 2'b00;
            default:   return 2'b11;
        endcase
    endfunction

    // Legalise a mode code: the reserved value behaves as off
    function automatic ss_mode_e legal_mode(input logic [1:0] code);
        case (code)
            2'b01:   return SS_QTR;
            2'b11:   return SS_FULL;
            default: return SS_OFF;
        endcase
    endfunction

endpackage

// File: rtl/ssc_strap_latch.sv
module ssc_strap_latch
    import ssc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good,
    input  logic [1:0] strap_lvl,
    output logic       seen,
    output logic [1:0] strap_rb
);
    logic pg_q;
    logic pg_rise;

    assign pg_rise = pwr_good && !pg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q     <= 1'b0;
            seen     <= 1'b0;
            strap_rb <= 2'b00;
        end else begin
            pg_q <= pwr_good;
            if (pg_rise && !seen) begin
                seen     <= 1'b1;
                strap_rb <= strap_code(strap_lvl);
            end
        end
    end

    // R2: once captured, the readback never moves again
    p_latch_once_r2: assert property (@(posedge clk) disable iff (rst)
        $past(seen) |-> $stable(strap_rb));

endmodule

// File: rtl/ssc_mode_pick.sv
module ssc_mode_pick
    import ssc_pkg::*;
(
    input  logic       seen,
    input  logic [1:0] strap_rb,
    input  logic       sw_ovr_en,
    input  logic [1:0] sw_mode,
    output ss_mode_e   req
);
    logic [1:0] raw;

    always_comb begin
        raw = sw_ovr_en ? sw_mode : strap_rb;
        if (!seen) req = SS_OFF;
        else       req = legal_mode(raw);
    end

endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
    import ssc_pkg::*;
#(
    parameter int TICK_DIV   = 4,
    parameter int HALF_STEPS = 16,
    parameter int STEP_QTR   = 4,
    parameter int MAG_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seen,
    input  ss_mode_e         req,
    output ss_mode_e         cur,
    output logic [MAG_W-1:0] mag
);
    localparam int STEP_FULL = 2 * STEP_QTR;
    localparam int CNT_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    function automatic logic [MAG_W-1:0] step_of(input ss_mode_e m);
        case (m)
            SS_QTR:  return MAG_W'(STEP_QTR);
            SS_FULL: return MAG_W'(STEP_FULL);
            default: return '0;
        endcase
    endfunction

    function automatic logic [MAG_W-1:0] depth_of(input ss_mode_e m);
        case (m)
            SS_QTR:  return MAG_W'(HALF_STEPS * STEP_QTR);
            SS_FULL: return MAG_W'(HALF_STEPS * STEP_FULL);
            default: return '0;
        endcase
    endfunction

    logic [CNT_W-1:0] tcnt;
    logic             tick;
    logic             rising;
    logic [MAG_W-1:0] up_next;
    logic [MAG_W-1:0] load_step;

    assign tick      = (tcnt == CNT_W'(TICK_DIV - 1));
    assign up_next   = mag + step_of(cur);
    assign load_step = step_of(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt   <= '0;
            mag    <= '0;
            cur    <= SS_OFF;
            rising <= 1'b0;
        end else begin
            tcnt <= tick ? '0 : tcnt + 1'b1;
            if (tick) begin
                if (mag == '0) begin
                    cur    <= req;
                    mag    <= load_step;
                    rising <= (load_step != depth_of(req));
                end else if (rising) begin
                    mag    <= up_next;
                    rising <= (up_next != depth_of(cur));
                end else begin
                    mag    <= mag - step_of(cur);
                end
            end
        end
    end

    // R3: nothing is modulated before the strap is captured
    p_idle_before_pg_r3: assert property (@(posedge clk) disable iff (rst)
        !seen |-> (mag == '0 && cur == SS_OFF));

    // R6: magnitude never exceeds the active depth
    p_depth_r6: assert property (@(posedge clk) disable iff (rst)
        mag <= depth_of(cur));

    // R7: every move is exactly one step of the active mode
    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (mag != $past(mag)) |->
            (((mag > $past(mag)) ? (mag - $past(mag)) : ($past(mag) - mag))
             == step_of(cur)));

    // R8: applied mode moves only out of a zero offset
    p_mode_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (cur != $past(cur)) |-> ($past(mag) == '0));

endmodule

// File: rtl/ssc_mode_sel.sv
module ssc_mode_sel
    import ssc_pkg::*;
#(
    parameter int TICK_DIV   = 4,
    parameter int HALF_STEPS = 16,
    parameter int STEP_QTR   = 4,
    parameter int MAG_W      = $clog2(HALF_STEPS * 2 * STEP_QTR + 1),
    parameter int OFS_W      = MAG_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_good,
    input  logic [1:0]       strap_lvl,
    input  logic             sw_ovr_en,
    input  logic [1:0]       sw_mode,
    output logic [1:0]       strap_rb,
    output logic [1:0]       mode_act,
    output logic [OFS_W-1:0] div_ofs
);
    logic             seen;
    ss_mode_e         req;
    ss_mode_e         cur;
    logic [MAG_W-1:0] mag;

    ssc_strap_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .pwr_good  (pwr_good),
        .strap_lvl (strap_lvl),
        .seen      (seen),
        .strap_rb  (strap_rb)
    );

    ssc_mode_pick u_pick (
        .seen      (seen),
        .strap_rb  (strap_rb),
        .sw_ovr_en (sw_ovr_en),
        .sw_mode   (sw_mode),
        .req       (req)
    );

    ssc_tri_gen #(
        .TICK_DIV   (TICK_DIV),
        .HALF_STEPS (HALF_STEPS),
        .STEP_QTR   (STEP_QTR),
        .MAG_W      (MAG_W)
    ) u_tri (
        .clk  (clk),
        .rst  (rst),
        .seen (seen),
        .req  (req),
        .cur  (cur),
        .mag  (mag)
    );

    assign mode_act = cur;
    assign div_ofs  = -$signed({1'b0, mag});

endmodule

// File: tb/ssc_mode_sel_tb.sv
module ssc_mode_sel_tb;
    localparam int OFS_W = 9;
    localparam int PERIOD = 128;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pwr_good = 1'b0;
    logic [1:0]       strap_lvl = 2'b00;
    logic             sw_ovr_en = 1'b0;
    logic [1:0]       sw_mode = 2'b00;
    logic [1:0]       strap_rb;
    logic [1:0]       mode_act;
    logic [OFS_W-1:0] div_ofs;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ssc_mode_sel u_dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .strap_lvl(strap_lvl),
        .sw_ovr_en(sw_ovr_en), .sw_mode(sw_mode), .strap_rb(strap_rb),
        .mode_act(mode_act), .div_ofs(div_ofs)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; pwr_good = 1'b0; sw_ovr_en = 1'b0; sw_mode = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic pg_pulse();
        @(negedge clk); pwr_good = 1'b1;
        repeat (3) @(negedge clk);
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Observe n cycles: extremes, largest step, trough spacing, bad mode moves
    task automatic watch(input int n, input int tgt, output int mn, output int mx,
                         output int mxstep, output int per, output int badm);
        int prev, prev_mode, t_last, cnt;
        @(negedge clk);
        prev = $signed(div_ofs); prev_mode = mode_act;
        mn = prev; mx = prev; mxstep = 0; per = 0; badm = 0; t_last = -1; cnt = 0;
        for (int i = 1; i < n; i++) begin
            int v, d;
            @(negedge clk);
            v = $signed(div_ofs);
            d = (v > prev) ? v - prev : prev - v;
            if (d > mxstep) mxstep = d;
            if (v < mn) mn = v;
            if (v > mx) mx = v;
            if (mode_act != prev_mode && prev != 0) badm++;
            if (v == tgt && prev != tgt) begin
                if (t_last >= 0 && per == 0) per = i - t_last;
                t_last = i;
            end
            prev = v; prev_mode = mode_act; cnt++;
        end
    endtask

    task automatic t_reset_state();
        int mn, mx, st, per, bm;
        do_reset();
        chk("R1 readback after reset", strap_rb, 0);
        chk("R3 mode after reset", mode_act, 0);
        sw_ovr_en = 1'b1; sw_mode = 2'b11; strap_lvl = 2'b10;
        watch(200, -128, mn, mx, st, per, bm);
        chk("R3 no offset before power-good (min)", mn, 0);
        chk("R3 mode stays off before power-good", mode_act, 0);
        sw_ovr_en = 1'b0; sw_mode = 2'b00;
    endtask

    task automatic t_strap_mid();
        int mn, mx, st, per, bm;
        do_reset();
        strap_lvl = 2'b01;
        pg_pulse();
        chk("R1 mid strap readback", strap_rb, 1);
        strap_lvl = 2'b10;
        pg_pulse();
        chk("R2 no re-latch on second power-good", strap_rb, 1);
        sw_mode = 2'b11;  // ignored while override is clear
        watch(400, -64, mn, mx, st, per, bm);
        chk("R4 strap mid depth, sw_mode ignored", mn, -64);
        chk("R6 offset never positive", mx, 0);
        chk("R7 quarter step size", st, 4);
        chk("R7 triangle period", per, PERIOD);
        chk("R4 mode_act follows strap", mode_act, 1);
    endtask

    task automatic t_override();
        int mn, mx, st, per, bm;
        sw_mode = 2'b11;
        repeat (40) @(negedge clk);
        sw_ovr_en = 1'b1;   // request mid-ramp
        watch(400, -128, mn, mx, st, per, bm);
        chk("R8 mode moves only from zero offset", bm, 0);
        chk("R7 no step beyond full step during switch", (st <= 8) ? 1 : 0, 1);
        watch(400, -128, mn, mx, st, per, bm);
        chk("R5 full depth by override", mn, -128);
        chk("R7 full step size", st, 8);
        chk("R7 full period", per, PERIOD);
        chk("R8 mode_act code full", mode_act, 3);
        sw_mode = 2'b10;
        watch(300, -128, mn, mx, st, per, bm);
        watch(200, -128, mn, mx, st, per, bm);
        chk("R5 reserved code acts as off (min)", mn, 0);
        chk("R5 reserved code mode_act", mode_act, 0);
        sw_mode = 2'b01;
        watch(300, -64, mn, mx, st, per, bm);
        watch(300, -64, mn, mx, st, per, bm);
        chk("R5 override quarter depth", mn, -64);
        chk("R8 mode_act code quarter", mode_act, 1);
        sw_mode = 2'b00;
        watch(300, -64, mn, mx, st, per, bm);
        watch(200, -64, mn, mx, st, per, bm);
        chk("R5 override off", mn, 0);
        sw_ovr_en = 1'b0;
    endtask

    task automatic t_strap_hi_lo();
        int mn, mx, st, per, bm;
        do_reset();
        strap_lvl = 2'b10;
        pg_pulse();
        chk("R1 high strap readback", strap_rb, 3);
        watch(400, -128, mn, mx, st, per, bm);
        chk("R6 full depth from strap", mn, -128);
        chk("R6 never positive full", mx, 0);
        do_reset();
        strap_lvl = 2'b00;
        pg_pulse();
        chk("R1 low strap readback", strap_rb, 0);
        watch(300, -64, mn, mx, st, per, bm);
        chk("R6 low strap keeps offset at zero", mn, 0);
    endtask

    initial begin
        t_reset_state();
        t_strap_mid();
        t_override();
        t_strap_hi_lo();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule